// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an external asynchronous static RAM. The RAM is organised as 2^18 words of 8 bits. The host hands over one request at a time through a valid/ready handshake: an address, a read/write flag and, for writes, a data byte. The controller then produces the pin-level sequence the RAM expects. It drives the address bus, a low-true and a high-true chip enable, a low-true output enable and a low-true write enable. It also drives the data bus through separate out, out-enable and in signals, so the three-state buffer itself lives at the chip pad.

Each timing phase lasts a whole number of clock cycles. The controller works these counts out from nanosecond limits and the clock period, rounding up. The limits are the access time, the write-pulse width and the time the RAM may keep driving the bus after it is released. A read keeps the RAM selected with the output enable low for the access count. It captures the bus on the last cycle of that window and returns the byte with a one-cycle strobe. It then waits out a turnaround gap with both enables released before it accepts new work. A write presents address and data for one cycle, pulses the write enable and holds address and data for one more cycle. The controller never turns on its own bus drivers while the RAM may still be driving the bus.

Top module: `asram_ctrl`

## Requirements
- R1: During and after a reset the RAM is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R2: `req_ready` is high only while the controller is idle, and the RAM is deselected whenever `req_ready` is high. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_write`=1 means write.
- R3: For a read taken at edge k, the RAM stays selected with `mem_we_n`=1 and `mem_oe_n`=0 for ACC_CYC = ceil(T_ACC_NS/CLK_NS) cycles. `rd_valid` is high for exactly the one cycle between edges k+ACC_CYC and k+ACC_CYC+1.
- R4: The byte returned on `rd_data` with `rd_valid` is the value the RAM drove on `mem_dq_in` for the requested address during the access window.
- R5: After a read, `req_ready` returns GAP_CYC = ceil(T_TURN_NS/CLK_NS) cycles after `rd_valid` rises. In that time both enables stay released. `mem_dq_oe` never rises fewer than GAP_CYC cycles after `mem_oe_n` was last low.
- R6: In a write, the RAM is selected with address and data driven for one cycle before `mem_we_n` falls. `mem_we_n` stays low for WP_CYC = ceil(T_WP_NS/CLK_NS) cycles. Address, data and select are held for one cycle after `mem_we_n` rises.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R8: `mem_we_n` is low only while the RAM is selected and `mem_oe_n` is high.
- R9: While the RAM stays selected from one cycle to the next, `mem_addr` does not change. The chip enables are never asserted before the address of their access is on the bus.
- R10: Changes on `req_addr`, `req_wdata` and `req_write` after a request has been taken have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_ce1_n | output | 1 | RAM enable, active low |
| mem_ce2 | output | 1 | RAM enable, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable of the pad drivers for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data from the RAM |

## Verification
The bench runs a small configuration with an 8-bit address. It writes every address, reads each one back and then interleaves reads and writes, which gives a read-to-write bus turnaround on every step. If the controller captured the bus one cycle late, after releasing OE, the bench's RAM model would already show its idle pattern and every readback would be wrong. A short turnaround gap makes the pad drivers turn on too soon after OE rises, and an off-by-one in any counter moves the strobe, the ready return or the write-pulse length away from the cycle counts the bench derives from the nanosecond limits. The bench also changes the request fields right after each hand-off: a controller that failed to latch them would store the changed byte.

// File: rtl/asram_pkg.sv
// Shared types and helpers for the asynchronous SRAM controller.
// Assumes every timing limit is given in whole nanoseconds.
package asram_pkg;

    // Sequencer phases; one RAM access walks a subset of these.
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_RD_ACC   = 3'd1,
        PH_RD_GAP   = 3'd2,
        PH_WR_SETUP = 3'd3,
        PH_WR_PULSE = 3'd4,
        PH_WR_HOLD  = 3'd5
    } phase_e;

    // Whole clock cycles covering a nanosecond limit, never fewer than one.
    function automatic int cyc_ceil(input int lim_ns, input int period_ns);
        int c;
        c = (lim_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Down-counter that times the length of one sequencer phase.
// Loading N-1 makes `expired` high on the N-th cycle after the load edge.
// Assumes the load value fits in CNT_W bits.
module asram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The phase ends in the cycle where the count has reached zero.
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/asram_seq_fsm.sv
// Phase sequencer for reads and writes to an asynchronous SRAM.
// It accepts a request only in idle and loads the phase timer on every timed
// phase entry. It flags the bus capture on the last cycle of the read access.
// Assumes the timer expires N cycles after it is loaded with N-1.
module asram_seq_fsm
    import asram_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int ACC_CYC = 6,
    parameter int GAP_CYC = 3,
    parameter int WP_CYC  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output phase_e           phase,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture
);

    localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);

    phase_e phase_q, phase_d;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Next phase, timer loads, request acceptance and capture flag.
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        phase_d = PH_WR_SETUP;
                    end else begin
                        phase_d  = PH_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = ACC_LD;
                    end
                end
            end
            PH_RD_ACC: begin
                if (tmr_expired) begin
                    capture  = 1'b1;
                    phase_d  = PH_RD_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_LD;
                end
            end
            PH_RD_GAP: begin
                if (tmr_expired) begin
                    phase_d = PH_IDLE;
                end
            end
            PH_WR_SETUP: begin
                phase_d  = PH_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LD;
            end
            PH_WR_PULSE: begin
                if (tmr_expired) begin
                    phase_d = PH_WR_HOLD;
                end
            end
            PH_WR_HOLD: begin
                phase_d = PH_IDLE;
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // Current phase for the pin decode.
    always_comb begin
        phase = phase_q;
    end

endmodule

// File: rtl/asram_req_latch.sv
// Holds the address and write data of the accepted request.
// They stay on the RAM pins until the next request is taken, so the address
// is steady before, during and after the select window.
// Assumes `accept` is high only for the hand-off cycle.
module asram_req_latch #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Capture the request fields on the hand-off edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/asram_rd_capture.sv
// Read-data register and its one-cycle valid strobe.
// Assumes `capture` marks the last cycle of the access window, while OE is
// still low and the RAM data is settled.
module asram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Sample the bus on the capture edge and strobe valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
// Asynchronous SRAM interface controller (top).
// It turns single valid/ready requests into chip-enable, output-enable and
// write-enable sequences. Phase lengths come from nanosecond limits rounded up
// to whole clock cycles. Assumes the pad buffer for the data bus is outside
// this block and uses mem_dq_out/mem_dq_oe/mem_dq_in.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_ACC_NS  = 55,
    parameter int T_TURN_NS = 30,
    parameter int T_WP_NS   = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int ACC_CYC = cyc_ceil(T_ACC_NS, CLK_NS);
    localparam int GAP_CYC = cyc_ceil(T_TURN_NS, CLK_NS);
    localparam int WP_CYC  = cyc_ceil(T_WP_NS, CLK_NS);
    localparam int MAX_A   = (ACC_CYC > GAP_CYC) ? ACC_CYC : GAP_CYC;
    localparam int MAX_CYC = (MAX_A > WP_CYC) ? MAX_A : WP_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    phase_e           phase;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;
    logic             selected;

    asram_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    asram_seq_fsm #(
        .CNT_W  (CNT_W),
        .ACC_CYC(ACC_CYC),
        .GAP_CYC(GAP_CYC),
        .WP_CYC (WP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .tmr_expired(tmr_expired),
        .phase      (phase),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .capture    (capture)
    );

    asram_req_latch #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out)
    );

    asram_rd_capture #(
        .DATA_W(DATA_W)
    ) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .dq_in   (mem_dq_in),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    // Pin decode: select, strobes and pad drive follow the current phase.
    always_comb begin
        selected  = (phase == PH_RD_ACC)   || (phase == PH_WR_SETUP) ||
                    (phase == PH_WR_PULSE) || (phase == PH_WR_HOLD);
        mem_ce1_n = !selected;
        mem_ce2   = selected;
        mem_oe_n  = (phase != PH_RD_ACC);
        mem_we_n  = (phase != PH_WR_PULSE);
        mem_dq_oe = (phase == PH_WR_SETUP) || (phase == PH_WR_PULSE) ||
                    (phase == PH_WR_HOLD);
        req_ready = (phase == PH_IDLE);
    end

endmodule

// File: rtl/asram_ctrl_chk.sv
// Protocol checker for the asynchronous SRAM controller, bound to its top.
// It watches only ports. Assumes GAP_CYC matches the controller's turnaround count.
module asram_ctrl_chk #(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 8,
    parameter int GAP_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    localparam int CW = $clog2(GAP_CYC + 2) + 1;
    localparam logic [CW-1:0] SAT = CW'(GAP_CYC + 1);

    logic          sel;
    logic [CW-1:0] since_oe;

    // RAM counts as selected only with both enables active.
    always_comb begin
        sel = !mem_ce1_n && mem_ce2;
    end

    // Saturating count of cycles since OE was last low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_oe <= SAT;
        end else if (!mem_oe_n) begin
            since_oe <= '0;
        end else if (since_oe < SAT) begin
            since_oe <= since_oe + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n &&
                    !mem_dq_oe && !rd_valid && req_ready));

    p_ready_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2));

    p_valid_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (since_oe >= CW'(GAP_CYC)));

    p_we_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(sel) && $past(mem_dq_oe) &&
                             $stable(mem_addr) && $stable(mem_dq_out)));

    p_we_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (sel && mem_dq_oe &&
                             $stable(mem_addr) && $stable(mem_dq_out)));

    p_no_contend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_we_needs_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (sel && mem_oe_n));

    p_addr_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .GAP_CYC(GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
// Self-checking bench: 8-bit address configuration and 20 ns clock. Expected cycle
// counts come from the nanosecond limits. A small RAM model answers reads.
module asram_ctrl_tb_top;

    localparam int AW      = 8;
    localparam int DW      = 8;
    localparam int PER     = 20;
    localparam int E_ACC   = (55 + PER - 1) / PER;
    localparam int E_GAP   = (30 + PER - 1) / PER;
    localparam int E_WP    = (45 + PER - 1) / PER;
    localparam logic [DW-1:0] IDLE_BUS = 8'hEE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int errors = 0;
    int v_contend = 0;
    int v_we = 0;
    int v_addr = 0;
    int v_gap = 0;
    int v_wp = 0;

    logic [DW-1:0] ram [256];

    always #(PER / 2) clk = ~clk;

    asram_ctrl #(
        .ADDR_W   (AW),
        .DATA_W   (DW),
        .CLK_NS   (PER),
        .T_ACC_NS (55),
        .T_TURN_NS(30),
        .T_WP_NS  (45)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .mem_addr  (mem_addr),
        .mem_ce1_n (mem_ce1_n),
        .mem_ce2   (mem_ce2),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_in (mem_dq_in)
    );

    // RAM model: drives only when selected, reading, and OE low.
    always_comb begin
        if (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n)
            mem_dq_in = ram[mem_addr];
        else
            mem_dq_in = IDLE_BUS;
    end

    always_ff @(posedge clk) begin
        if (!mem_ce1_n && mem_ce2 && !mem_we_n && mem_dq_oe)
            ram[mem_addr] <= mem_dq_out;
    end

    // Pin monitors sampled at the falling edge (R5, R6, R7, R8, R9).
    logic          p_sel = 1'b0;
    logic          p_dq_oe = 1'b0;
    logic          p_we_n = 1'b1;
    logic [AW-1:0] p_addr = '0;
    int            since_oe = 100;
    int            we_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) v_contend++;
            if (!mem_we_n && !(!mem_ce1_n && mem_ce2 && mem_oe_n)) v_we++;
            if (p_sel && !mem_ce1_n && mem_ce2 && (mem_addr != p_addr)) v_addr++;
            if (mem_dq_oe && !p_dq_oe && since_oe < E_GAP) v_gap++;
            if (!mem_we_n) we_run++;
            if (mem_we_n && !p_we_n) begin
                if (we_run != E_WP) v_wp++;
                we_run = 0;
            end
        end
        since_oe = !mem_oe_n ? 0 : since_oe + 1;
        p_sel   = !mem_ce1_n && mem_ce2;
        p_dq_oe = mem_dq_oe;
        p_we_n  = mem_we_n;
        p_addr  = mem_addr;
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int pass);
        return DW'((a * 37 + 11 + pass * 91) ^ (a >> 3));
    endfunction

    // Write one word; corrupt the request fields after the hand-off (R10).
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = ~a;
        req_wdata = ~d;
        while (!req_ready) @(negedge clk);
    endtask

    // Read one word; check strobe timing (R3), data (R4), ready return (R5).
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input logic timing);
        int vld_at;
        int rdy_at;
        int vld_len;
        logic [DW-1:0] got;
        vld_at  = -1;
        rdy_at  = -1;
        vld_len = 0;
        got     = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (n == 1) begin
                req_valid = 1'b0;
                req_write = 1'b1;
                req_addr  = ~a;
            end
            if (rd_valid) begin
                vld_len++;
                if (vld_at < 0) begin
                    vld_at = n;
                    got = rd_data;
                end
            end
            if (req_ready && rdy_at < 0) rdy_at = n;
            if (rdy_at >= 0) break;
        end
        check("R4 read data", got == exp, int'(got), int'(exp));
        if (timing) begin
            check("R3 strobe cycle", vld_at == E_ACC + 1, vld_at, E_ACC + 1);
            check("R3 strobe width", vld_len == 1, vld_len, 1);
            check("R5 ready return", rdy_at == E_ACC + E_GAP + 1, rdy_at, E_ACC + E_GAP + 1);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values at the pins.
        check("R1 reset pins",
              mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
              {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 6'b101100);
        check("R1 reset ready", req_ready == 1'b1, int'(req_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle means ready with the RAM deselected.
        check("R2 idle", req_ready && mem_ce1_n && !mem_ce2, int'(req_ready), 1);

        // Sweep 1: write every address, then read each back (R4, R6, R10).
        for (int a = 0; a < 256; a++) do_write(AW'(a), pat(a, 0));
        for (int a = 0; a < 256; a++) do_read(AW'(a), pat(a, 0), a < 8);

        // Sweep 2: read-to-write turnarounds on every step (R5, R7).
        for (int a = 0; a < 256; a += 5) begin
            do_read(AW'(a), pat(a, 0), 1'b1);
            do_write(AW'(a), pat(a, 1));
            do_read(AW'(a), pat(a, 1), 1'b0);
        end

        // Request held low while idle: nothing starts (R2).
        repeat (5) @(negedge clk);
        check("R2 no spurious access", req_ready && mem_ce1_n && !rd_valid, int'(mem_ce1_n), 1);

        check("R5 turnaround gap", v_gap == 0, v_gap, 0);
        check("R6 write pulse width", v_wp == 0, v_wp, 0);
        check("R7 no bus contention", v_contend == 0, v_contend, 0);
        check("R8 write only selected", v_we == 0, v_we, 0);
        check("R9 address steady", v_addr == 0, v_addr, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule